// File: doc/BRIEF.md
# Stack Push/Pop Instruction Sequencer

This block runs the sixteen-bit stack transfer instructions of a small eight-bit processor over a byte-wide memory bus, one clock per T-state. When idle it samples `start`. It then fetches the opcode byte at the program counter, or two bytes when an index-register prefix comes first. It steps through the machine cycles of that instruction with the exact T-state count of each cycle. A push stores a register pair as two bytes below the stack pointer. A pop reloads a pair from the two bytes at the stack pointer.

The block holds the four general pairs, the two index registers, the stack pointer and the program counter, and presents all of them as outputs. Each memory access strobes `mem_rd` or `mem_wr` in the first T-state of its machine cycle. Read data must be valid in that same clock. `done` marks the final T-state of every instruction. An opcode the block does not recognise ends early with `illegal` set and leaves the registers as they were.

Top module: `stk_seq`

## Requirements
- R1: After reset, SP equals SP_RESET (default 0x0300) and PC equals PC_RESET (default 0). All six pairs are zero, and `mem_rd`, `mem_wr`, `done` and `illegal` are low.
- R2: Byte 11rs0101 is a push. rs 00 selects BC, 01 selects DE, 10 selects HL and 11 selects AF, with A as the high byte and F as the low byte. The push writes the high byte to SP-1, then the low byte to SP-2, and leaves SP two lower.
- R3: Byte 11rs0001 is a pop, with the same rs encoding as R2. The pop reads the low byte from SP, then the high byte from SP+1, loads the pair (F comes from the low byte for AF), and leaves SP two higher.
- R4: A plain push lasts 11 T-states in three machine cycles of 5, 3 and 3, with one strobe in each.
- R5: A plain pop lasts 10 T-states in three machine cycles of 4, 3 and 3, with one strobe in each.
- R6: Prefix 0xDD selects IX and prefix 0xFD selects IY. A prefix followed by 0xE5 pushes that register in 15 T-states, in cycles of 4, 5, 3 and 3.
- R7: A prefix followed by 0xE1 pops into that index register in 14 T-states, in cycles of 4, 4, 3 and 3.
- R8: PC advances by exactly one for each opcode byte fetched and changes at no other time.
- R9: T-states are counted from the clock after the one in which `start` is sampled high while idle. `done` is high for exactly one clock: the last T-state.
- R10: A first byte that is neither a push, a pop nor a prefix ends the instruction at its 4th T-state with `done` and `illegal` both high. A prefix followed by any byte other than 0xE5 or 0xE1 ends the same way at the 8th T-state. In both cases SP and the pairs are unchanged.
- R11: Each access has exactly one strobe, in the first T-state of its machine cycle. `mem_rd` and `mem_wr` are never high together. `start` has no effect while an instruction is running.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction; sampled only when idle |
| mem_addr | output | AW | Address of the current access |
| mem_rd | output | 1 | Read strobe; data is sampled at the end of that clock |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Byte to be written |
| mem_rdata | input | DW | Byte read from memory, valid in the strobe clock |
| done | output | 1 | High in the last T-state of an instruction |
| illegal | output | 1 | High together with done when the opcode was not recognised |
| reg_bc | output | 2*DW | BC pair |
| reg_de | output | 2*DW | DE pair |
| reg_hl | output | 2*DW | HL pair |
| reg_af | output | 2*DW | AF pair (A high byte, F low byte) |
| reg_ix | output | 2*DW | IX index register |
| reg_iy | output | 2*DW | IY index register |
| reg_sp | output | AW | Stack pointer |
| reg_pc | output | AW | Program counter |

## Verification
The checks assume that memory returns the byte combinationally in the same clock as the read strobe. They also assume that `start` is raised only while the block is idle, apart from the deliberate test that holds it high through a busy instruction. The bench memory answers every address within one clock. It loads program and stack bytes only between instructions, so no preload write ever coincides with a write from the block. Every stack address the bench uses stays inside its 1024-byte model, so address truncation never aliases two bytes.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_F1,
      PH_F2,
      PH_X1,
      PH_X2
   } phase_t;

   typedef enum logic [1:0] {
      CL_PUSH,
      CL_POP,
      CL_PFX,
      CL_BAD
   } cls_t;

   localparam int NREG   = 6;
   localparam int SEL_W  = 3;
   localparam int TCNT_W = 3;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
   import stk_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] op,
   input  logic          second,
   output cls_t          cls,
   output logic [1:0]    rs
);
   assign rs = op[5:4];

   always_comb begin
      if (!second) begin
         if (op[7:6] == 2'b11 && op[3:0] == 4'b0101)
            cls = CL_PUSH;
         else if (op[7:6] == 2'b11 && op[3:0] == 4'b0001)
            cls = CL_POP;
         else if (op[7:6] == 2'b11 && op[4:0] == 5'b11101)
            cls = CL_PFX;
         else
            cls = CL_BAD;
      end else begin
         if (op == DW'(8'hE5))
            cls = CL_PUSH;
         else if (op == DW'(8'hE1))
            cls = CL_POP;
         else
            cls = CL_BAD;
      end
   end
endmodule

// File: rtl/stk_tcount.sv
module stk_tcount #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] len,
   output logic [TW-1:0] tcnt,
   output logic          last
);
   assign last = run && (tcnt == len - TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         tcnt <= '0;
      else if (!run || last)
         tcnt <= '0;
      else
         tcnt <= tcnt + TW'(1);
   end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
   parameter int PW = 16,
   parameter int NR = 6,
   parameter int SW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [SW-1:0]   widx,
   input  logic [PW-1:0]   wdata,
   input  logic [SW-1:0]   ridx,
   output logic [PW-1:0]   rdata,
   output logic [NR*PW-1:0] flat
);
   for (genvar i = 0; i < NR; i++) begin : g_pair
      logic [PW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (we && widx == SW'(i))
            q <= wdata;
      end
      assign flat[i*PW +: PW] = q;
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NR; k++)
         if (ridx == SW'(k))
            rdata = flat[k*PW +: PW];
   end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int          AW       = 16,
   parameter int          DW       = 8,
   parameter logic [15:0] SP_RESET = 16'h0300,
   parameter logic [15:0] PC_RESET = 16'h0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            done,
   output logic            illegal,
   output logic [2*DW-1:0] reg_bc,
   output logic [2*DW-1:0] reg_de,
   output logic [2*DW-1:0] reg_hl,
   output logic [2*DW-1:0] reg_af,
   output logic [2*DW-1:0] reg_ix,
   output logic [2*DW-1:0] reg_iy,
   output logic [AW-1:0]   reg_sp,
   output logic [AW-1:0]   reg_pc
);
   localparam int PW = 2 * DW;

   if (DW != 8) begin : g_dw_bad
      $error("stk_seq: opcode decode needs DW == 8");
   end
   if (AW < 8 || AW > 16) begin : g_aw_bad
      $error("stk_seq: AW must be in 8..16");
   end

   phase_t              ph;
   cls_t                cls_q;
   logic [SEL_W-1:0]    sel_q;
   logic [DW-1:0]       tmp_lo, tmp_hi;
   logic [AW-1:0]       sp_q, pc_q;

   cls_t                dcls;
   logic [1:0]          drs;
   logic [TCNT_W-1:0]   len, tcnt;
   logic                last, run, cap, xfer, xfer_push;
   logic [PW-1:0]       rpair;
   logic [NREG*PW-1:0]  flat;
   logic                rf_we;

   stk_decode #(.DW(DW)) u_dec (
      .op(mem_rdata), .second(ph == PH_F2), .cls(dcls), .rs(drs)
   );

   assign run = (ph != PH_IDLE);

   always_comb begin
      case (ph)
         PH_F1, PH_F2: len = (cls_q == CL_PUSH) ? TCNT_W'(5) : TCNT_W'(4);
         PH_X1, PH_X2: len = TCNT_W'(3);
         default:      len = TCNT_W'(4);
      endcase
   end

   stk_tcount #(.TW(TCNT_W)) u_tc (
      .clk(clk), .rst_n(rst_n), .run(run), .len(len), .tcnt(tcnt), .last(last)
   );

   assign cap       = run && (tcnt == '0);
   assign xfer      = (ph == PH_X1) || (ph == PH_X2);
   assign xfer_push = (cls_q == CL_PUSH);

   assign done    = last && (ph == PH_X2 || cls_q == CL_BAD);
   assign illegal = last && (cls_q == CL_BAD);
   assign rf_we   = last && (ph == PH_X2) && !xfer_push;

   stk_regfile #(.PW(PW), .NR(NREG), .SW(SEL_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(sel_q),
      .wdata({tmp_hi, tmp_lo}), .ridx(sel_q), .rdata(rpair), .flat(flat)
   );

   assign mem_rd = cap && ((ph == PH_F1) || (ph == PH_F2) || (xfer && !xfer_push));
   assign mem_wr = cap && xfer && xfer_push;

   always_comb begin
      case (ph)
         PH_X1:   mem_addr = xfer_push ? sp_q - AW'(1) : sp_q;
         PH_X2:   mem_addr = xfer_push ? sp_q - AW'(2) : sp_q + AW'(1);
         default: mem_addr = pc_q;
      endcase
   end

   assign mem_wdata = (ph == PH_X2) ? rpair[DW-1:0] : rpair[PW-1:DW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         cls_q  <= CL_BAD;
         sel_q  <= '0;
         tmp_lo <= '0;
         tmp_hi <= '0;
         sp_q   <= AW'(SP_RESET);
         pc_q   <= AW'(PC_RESET);
      end else begin
         if (cap && ph == PH_F1) begin
            cls_q <= dcls;
            sel_q <= {1'b0, drs};
            pc_q  <= pc_q + AW'(1);
         end
         if (cap && ph == PH_F2) begin
            cls_q <= dcls;
            sel_q <= sel_q[1] ? SEL_W'(5) : SEL_W'(4);
            pc_q  <= pc_q + AW'(1);
         end
         if (cap && ph == PH_X1 && !xfer_push) tmp_lo <= mem_rdata;
         if (cap && ph == PH_X2 && !xfer_push) tmp_hi <= mem_rdata;
         if (last && ph == PH_X2)
            sp_q <= xfer_push ? sp_q - AW'(2) : sp_q + AW'(2);

         case (ph)
            PH_IDLE: if (start) ph <= PH_F1;
            PH_F1: if (last) begin
               case (cls_q)
                  CL_PFX:  ph <= PH_F2;
                  CL_BAD:  ph <= PH_IDLE;
                  default: ph <= PH_X1;
               endcase
            end
            PH_F2: if (last) ph <= (cls_q == CL_BAD) ? PH_IDLE : PH_X1;
            PH_X1: if (last) ph <= PH_X2;
            PH_X2: if (last) ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign reg_bc = flat[0*PW +: PW];
   assign reg_de = flat[1*PW +: PW];
   assign reg_hl = flat[2*PW +: PW];
   assign reg_af = flat[3*PW +: PW];
   assign reg_ix = flat[4*PW +: PW];
   assign reg_iy = flat[5*PW +: PW];
   assign reg_sp = sp_q;
   assign reg_pc = pc_q;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic          done,
   input logic          illegal,
   input logic [AW-1:0] reg_sp,
   input logic [AW-1:0] reg_pc
);
   // R11
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R11
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   // R10
   illegal_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |=> $stable(reg_sp));

   // R2
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr == AW'(reg_sp - 1) || mem_addr == AW'(reg_sp - 2)));

   // R3
   sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(reg_sp));

   // R8
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_pc) |-> reg_pc == AW'($past(reg_pc) + 1));
endmodule

bind stk_seq stk_seq_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .mem_addr(mem_addr), .done(done), .illegal(illegal),
   .reg_sp(reg_sp), .reg_pc(reg_pc)
);

// File: tb/stk_seq_tb.sv
module stk_seq_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, start;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, done, illegal;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [15:0] reg_bc, reg_de, reg_hl, reg_af, reg_ix, reg_iy, reg_sp, reg_pc;

   logic [7:0]  mem [0:1023];
   logic        pl_en;
   logic [9:0]  pl_addr;
   logic [7:0]  pl_data;

   int n_chk = 0, n_fail = 0;
   logic [15:0] exp_pc = 16'h0000;
   logic [15:0] exp_sp = 16'h0300;

   always #(CLK_PERIOD/2) clk = ~clk;

   stk_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
      .reg_bc(reg_bc), .reg_de(reg_de), .reg_hl(reg_hl), .reg_af(reg_af),
      .reg_ix(reg_ix), .reg_iy(reg_iy), .reg_sp(reg_sp), .reg_pc(reg_pc)
   );

   assign mem_rdata = mem[mem_addr[9:0]];

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
      else if (pl_en) mem[pl_addr] <= pl_data;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [15:0] a, input logic [7:0] d);
      pl_en = 1'b1; pl_addr = a[9:0]; pl_data = d;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   function automatic logic [15:0] get_reg(input int i);
      case (i)
         0: return reg_bc;
         1: return reg_de;
         2: return reg_hl;
         3: return reg_af;
         4: return reg_ix;
         default: return reg_iy;
      endcase
   endfunction

   task automatic exec(input logic [7:0] b0, input logic [7:0] b1, input int nb, input int hold,
                       output int nt, output int ns, output logic ill, output logic dn_after);
      poke(exp_pc, b0);
      if (nb > 1) poke(exp_pc + 16'd1, b1);
      start = 1'b1;
      nt = 0; ns = 0;
      do begin
         @(negedge clk);
         nt++;
         if (nt >= hold) start = 1'b0;
         if (mem_rd || mem_wr) ns++;
      end while (!done && nt < 60);
      ill = illegal;
      @(negedge clk);
      dn_after = done;
      exp_pc = exp_pc + 16'(nb);
   endtask

   task automatic t_pop(input logic [7:0] b0, input logic [7:0] b1, input int nb, input int idx,
                        input logic [15:0] val, input int exp_t, input string tag_t);
      int nt, ns; logic ill, da;
      exec(b0, b1, nb, 1, nt, ns, ill, da);
      exp_sp = exp_sp + 16'd2;
      chk(get_reg(idx) == val, "R3 pop value", get_reg(idx), val);
      chk(reg_sp == exp_sp, "R3 pop SP", reg_sp, exp_sp);
      chk(nt == exp_t, tag_t, nt, exp_t);
      chk(ns == nb + 2, "R11 pop strobes", ns, nb + 2);
      chk(reg_pc == exp_pc, "R8 pop PC", reg_pc, exp_pc);
      chk(!ill && !da, "R9 pop done/illegal", {ill, da}, 0);
   endtask

   task automatic t_push(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                         input logic [15:0] val, input int exp_t, input string tag_t);
      int nt, ns; logic ill, da;
      exec(b0, b1, nb, 1, nt, ns, ill, da);
      chk(mem[10'(exp_sp - 16'd1)] == val[15:8], "R2 push high byte", mem[10'(exp_sp - 16'd1)], val[15:8]);
      chk(mem[10'(exp_sp - 16'd2)] == val[7:0], "R2 push low byte", mem[10'(exp_sp - 16'd2)], val[7:0]);
      exp_sp = exp_sp - 16'd2;
      chk(reg_sp == exp_sp, "R2 push SP", reg_sp, exp_sp);
      chk(nt == exp_t, tag_t, nt, exp_t);
      chk(ns == nb + 2, "R11 push strobes", ns, nb + 2);
      chk(reg_pc == exp_pc, "R8 push PC", reg_pc, exp_pc);
      chk(!ill && !da, "R9 push done/illegal", {ill, da}, 0);
   endtask

   task automatic t_reset;
      chk(reg_sp == 16'h0300, "R1 SP reset", reg_sp, 16'h0300);
      chk(reg_pc == 16'h0000, "R1 PC reset", reg_pc, 0);
      chk((reg_bc | reg_de | reg_hl | reg_af | reg_ix | reg_iy) == 16'h0, "R1 pairs zero",
          reg_bc | reg_de | reg_hl | reg_af | reg_ix | reg_iy, 0);
      chk({mem_rd, mem_wr, done, illegal} == 4'b0, "R1 outputs idle",
          {mem_rd, mem_wr, done, illegal}, 0);
   endtask

   task automatic t_busy_start;
      int nt, ns; logic ill, da;
      logic [15:0] hl0;
      hl0 = reg_hl;
      exec(8'hD1, 8'h00, 1, 3, nt, ns, ill, da);
      exp_sp = exp_sp + 16'd2;
      repeat (6) @(negedge clk);
      chk(reg_de == 16'h4433, "R11 DE after held start", reg_de, 16'h4433);
      chk(reg_sp == exp_sp, "R11 single SP step", reg_sp, exp_sp);
      chk(reg_pc == exp_pc, "R11 single PC step", reg_pc, exp_pc);
      chk(reg_hl == hl0, "R11 HL untouched", reg_hl, hl0);
   endtask

   task automatic t_illegal(input logic [7:0] b0, input logic [7:0] b1, input int nb, input int exp_t);
      int nt, ns; logic ill, da;
      logic [15:0] de0;
      de0 = reg_de;
      exec(b0, b1, nb, 1, nt, ns, ill, da);
      chk(ill == 1'b1, "R10 illegal flag", ill, 1);
      chk(nt == exp_t, "R10 illegal T-states", nt, exp_t);
      chk(reg_pc == exp_pc, "R10 illegal PC", reg_pc, exp_pc);
      chk(reg_sp == exp_sp, "R10 illegal SP", reg_sp, exp_sp);
      chk(reg_de == de0, "R10 illegal pair kept", reg_de, de0);
      chk(!da, "R9 done one clock", da, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; pl_en = 1'b0; pl_addr = '0; pl_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      poke(16'h0300, 8'h34); poke(16'h0301, 8'h12);
      poke(16'h0302, 8'h78); poke(16'h0303, 8'h56);
      poke(16'h0304, 8'hBC); poke(16'h0305, 8'h9A);
      poke(16'h0306, 8'h5A); poke(16'h0307, 8'hA5);
      poke(16'h0308, 8'h11); poke(16'h0309, 8'h22);
      poke(16'h030A, 8'h33); poke(16'h030B, 8'h44);

      t_pop(8'hC1, 8'h00, 1, 0, 16'h1234, 10, "R5 pop BC T-states");
      t_pop(8'hD1, 8'h00, 1, 1, 16'h5678, 10, "R5 pop DE T-states");
      t_pop(8'hE1, 8'h00, 1, 2, 16'h9ABC, 10, "R5 pop HL T-states");
      t_pop(8'hF1, 8'h00, 1, 3, 16'hA55A, 10, "R5 pop AF T-states");
      t_pop(8'hDD, 8'hE1, 2, 4, 16'h2211, 14, "R7 pop IX T-states");
      t_pop(8'hFD, 8'hE1, 2, 5, 16'h4433, 14, "R7 pop IY T-states");

      t_push(8'hC5, 8'h00, 1, 16'h1234, 11, "R4 push BC T-states");
      t_push(8'hF5, 8'h00, 1, 16'hA55A, 11, "R4 push AF T-states");
      t_push(8'hDD, 8'hE5, 2, 16'h2211, 15, "R6 push IX T-states");
      t_push(8'hFD, 8'hE5, 2, 16'h4433, 15, "R6 push IY T-states");

      t_busy_start();
      t_illegal(8'h00, 8'h00, 1, 4);
      t_illegal(8'hDD, 8'h00, 2, 8);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule